// File: doc/BRIEF.md
# FIFO Reset and Retransmit Controller

This block drives the pointer-clear controls of one FIFO whose write side runs on one clock and whose read side runs on another. An active-low master reset clears both pointers and the read-side output register at once, holds them clear while it stays low, and captures the static configuration word on its rising edge. A second active-low request pin has two meanings, chosen by a mode input. With the mode input low it is a partial reset: both pointers and the output register are cleared, and the configuration captured earlier is kept. With the mode input high it is a retransmit: only the read pointer returns to the first location.

Each request passes through a two-stage synchronizer in each clock domain. The clear outputs of each domain follow the synchronized requests. While master reset is low, a saturating counter in each domain counts clock edges. When master reset is released, the block raises an error flag if either domain saw fewer than the minimum number of edges.

Top module: `fifo_rst_ctl`

## Requirements
- R1: While `mrst_n` is low, `wr_clr`, `rd_clr` and `oreg_clr` are 1 and `cfg_keep` is 0. They take these values as soon as `mrst_n` falls, without waiting for a clock edge.
- R2: After `mrst_n` rises, `wr_clr` stays 1 through the first `clk_a` rising edge and is 0 after the second. `rd_clr` and `oreg_clr` do the same on `clk_b`.
- R3: With `rt_mode` = 0, a low `prt_n` is a partial reset. `wr_clr` and `cfg_keep` become 1 on the second `clk_a` edge after the request. `rd_clr` and `oreg_clr` become 1 on the second `clk_b` edge. None of them is 1 after the first edge.
- R4: With `rt_mode` = 1, a low `prt_n` is a retransmit. `rd_clr` becomes 1 on the second `clk_b` edge. `wr_clr`, `oreg_clr` and `cfg_keep` stay 0.
- R5: `cfg_q` takes the value of `cfg_in` at the rising edge of `mrst_n`. It does not change afterwards, whatever `cfg_in`, `prt_n` or `rt_mode` do.
- R6: At each rising edge of `mrst_n`, `short_err` is set to 1 if fewer than 4 `clk_a` rising edges, or fewer than 4 `clk_b` rising edges, occurred while `mrst_n` was low. Otherwise it is set to 0. It holds that value until the next release.
- R7: When `prt_n` returns high, each clear raised by the request stays 1 through the first edge of its own clock and is 0 after the second.
- R8: Master reset takes priority over a pending partial reset: `cfg_keep` drops to 0 as soon as `mrst_n` falls, even while `prt_n` is still low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| prt_n | input | 1 | Partial reset or retransmit request, active low |
| rt_mode | input | 1 | 0 selects partial reset, 1 selects retransmit |
| cfg_in | input | CFG_W | Configuration word captured when master reset rises |
| wr_clr | output | 1 | Write-pointer clear, clk_a domain |
| rd_clr | output | 1 | Read-pointer clear, clk_b domain |
| oreg_clr | output | 1 | Output-register clear, clk_b domain |
| cfg_keep | output | 1 | Partial reset in progress with configuration kept, clk_a domain |
| cfg_q | output | CFG_W | Captured configuration |
| short_err | output | 1 | Master reset released too early |

## Verification
The bench sweeps the length of master reset over one to eight write-clock edges. The slower read clock then falls short of four edges in some runs where the write clock did not. A checker that looked at only one domain, or that counted off by one, would get those runs wrong. It drives a partial reset and a retransmit with identical timing. A design that decoded the mode inverted, or that cleared the output register on a retransmit, would raise the wrong clears. It also checks clears one edge early, to catch a missing synchronizer stage. It starts a master reset on top of a pending partial reset to confirm that the configuration-keep flag drops at once.

// File: rtl/fifo_rst_ctl.sv
module fifo_rst_ctl #(
  parameter int CFG_W     = 6,
  parameter int MIN_EDGES = 4,
  parameter int SYNC      = 2
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             mrst_n,
  input  logic             prt_n,
  input  logic             rt_mode,
  input  logic [CFG_W-1:0] cfg_in,
  output logic             wr_clr,
  output logic             rd_clr,
  output logic             oreg_clr,
  output logic             cfg_keep,
  output logic [CFG_W-1:0] cfg_q,
  output logic             short_err
);

  localparam int CW = $clog2(MIN_EDGES + 1);
  localparam logic [CW-1:0] NMIN = CW'(MIN_EDGES);

  logic [SYNC-1:0] mr_a, pr_a, rm_a;
  logic [SYNC-1:0] mr_b, pr_b, rm_b;
  logic [CW-1:0]   na, nb;

  always_ff @(posedge clk_a or negedge mrst_n)
    if (!mrst_n) begin
      mr_a <= '1;
      pr_a <= '0;
      rm_a <= '0;
    end else begin
      mr_a <= {mr_a[SYNC-2:0], 1'b0};
      pr_a <= {pr_a[SYNC-2:0], ~prt_n};
      rm_a <= {rm_a[SYNC-2:0], rt_mode};
    end

  always_ff @(posedge clk_b or negedge mrst_n)
    if (!mrst_n) begin
      mr_b <= '1;
      pr_b <= '0;
      rm_b <= '0;
    end else begin
      mr_b <= {mr_b[SYNC-2:0], 1'b0};
      pr_b <= {pr_b[SYNC-2:0], ~prt_n};
      rm_b <= {rm_b[SYNC-2:0], rt_mode};
    end

  wire mr_sa = mr_a[SYNC-1];
  wire pr_sa = pr_a[SYNC-1];
  wire rm_sa = rm_a[SYNC-1];
  wire mr_sb = mr_b[SYNC-1];
  wire pr_sb = pr_b[SYNC-1];
  wire rm_sb = rm_b[SYNC-1];

  assign wr_clr   = mr_sa | (pr_sa & ~rm_sa);
  assign cfg_keep = ~mr_sa & pr_sa & ~rm_sa;
  assign rd_clr   = mr_sb | pr_sb;
  assign oreg_clr = mr_sb | (pr_sb & ~rm_sb);

  always_ff @(posedge clk_a)
    if (!mr_a[0])        na <= '0;
    else if (na != NMIN) na <= na + 1'b1;

  always_ff @(posedge clk_b)
    if (!mr_b[0])        nb <= '0;
    else if (nb != NMIN) nb <= nb + 1'b1;

  always_ff @(posedge mrst_n) begin
    cfg_q     <= cfg_in;
    short_err <= (na < NMIN) || (nb < NMIN);
  end

  always @(posedge clk_a)
    if (!mrst_n)
      p_mrst_a_r1: assert (wr_clr && !cfg_keep) else $error("master reset not clearing write side");

  always @(posedge clk_b)
    if (!mrst_n)
      p_mrst_b_r1: assert (rd_clr && oreg_clr) else $error("master reset not clearing read side");

  p_keep_wr_r3: assert property (@(posedge clk_a) disable iff (!mrst_n)
    cfg_keep |-> wr_clr) else $error("keep without write clear");

  p_oreg_rd_r4: assert property (@(posedge clk_b) disable iff (!mrst_n)
    oreg_clr |-> rd_clr) else $error("output clear without read clear");

  p_cfg_hold_r5: assert property (@(posedge clk_a) disable iff (!mrst_n)
    (!mr_sa && !$past(mr_sa)) |-> $stable(cfg_q)) else $error("configuration changed");

endmodule

// File: tb/sim_fifo_rst_ctl.sv
module sim_fifo_rst_ctl;
  logic clk_a = 0, clk_b = 0;
  logic mrst_n, prt_n, rt_mode;
  logic [5:0] cfg_in;
  logic wr_clr, rd_clr, oreg_clr, cfg_keep, short_err;
  logic [5:0] cfg_q;
  int n_chk = 0, n_fail = 0, nbc = 0;
  logic [5:0] saved;

  always #4 clk_a = ~clk_a;
  always #6 clk_b = ~clk_b;

  fifo_rst_ctl u0 (.clk_a(clk_a), .clk_b(clk_b), .mrst_n(mrst_n), .prt_n(prt_n),
    .rt_mode(rt_mode), .cfg_in(cfg_in), .wr_clr(wr_clr), .rd_clr(rd_clr),
    .oreg_clr(oreg_clr), .cfg_keep(cfg_keep), .cfg_q(cfg_q), .short_err(short_err));

  always @(posedge clk_b) if (!mrst_n) nbc++;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic ea(); @(posedge clk_a); #1; endtask
  task automatic eb(); @(posedge clk_b); #1; endtask

  initial begin
    #500000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    mrst_n = 1; prt_n = 1; rt_mode = 0; cfg_in = 0;
    #1 mrst_n = 0;
    #1;
    chk("R1 wr_clr", wr_clr, 1);
    chk("R1 rd_clr", rd_clr, 1);
    chk("R1 oreg_clr", oreg_clr, 1);
    repeat (8) ea();
    cfg_in = 6'h15;
    mrst_n = 1;
    repeat (3) eb();
    chk("R5 first capture", cfg_q, 6'h15);

    for (int k = 1; k <= 8; k++) begin
      ea();
      cfg_in = 6'((k * 7) & 63);
      mrst_n = 0;
      nbc = 0;
      repeat (k) ea();
      mrst_n = 1;
      fork
        begin
          ea(); chk("R2 wr_clr edge1", wr_clr, 1);
          ea(); chk("R2 wr_clr edge2", wr_clr, 0);
        end
        begin
          eb(); chk("R2 rd_clr edge1", rd_clr, 1);
          eb(); chk("R2 rd_clr edge2", rd_clr, 0);
          chk("R2 oreg_clr edge2", oreg_clr, 0);
        end
      join
      chk("R6 short_err", short_err, ((k < 4) || (nbc < 4)) ? 1 : 0);
      chk("R5 capture", cfg_q, (k * 7) & 63);
      cfg_in = ~cfg_in;
    end

    saved = cfg_q;
    for (int m = 0; m <= 1; m++) begin
      ea();
      rt_mode = m[0];
      prt_n = 0;
      cfg_in = ~cfg_in;
      fork
        begin
          ea(); chk(m ? "R4 wr_clr edge1" : "R3 wr_clr edge1", wr_clr, 0);
          ea(); chk(m ? "R4 wr_clr" : "R3 wr_clr", wr_clr, m ? 0 : 1);
          chk(m ? "R4 cfg_keep" : "R3 cfg_keep", cfg_keep, m ? 0 : 1);
        end
        begin
          eb(); chk(m ? "R4 rd_clr edge1" : "R3 rd_clr edge1", rd_clr, 0);
          eb(); chk(m ? "R4 rd_clr" : "R3 rd_clr", rd_clr, 1);
          chk(m ? "R4 oreg_clr" : "R3 oreg_clr", oreg_clr, m ? 0 : 1);
        end
      join
      chk("R5 kept", cfg_q, saved);
      ea();
      prt_n = 1;
      fork
        begin
          ea(); chk("R7 wr_clr edge1", wr_clr, m ? 0 : 1);
          ea(); chk("R7 wr_clr edge2", wr_clr, 0);
        end
        begin
          eb(); chk("R7 rd_clr edge1", rd_clr, 1);
          eb(); chk("R7 rd_clr edge2", rd_clr, 0);
          chk("R7 oreg_clr edge2", oreg_clr, 0);
        end
      join
    end

    ea();
    rt_mode = 0;
    prt_n = 0;
    repeat (3) ea();
    chk("R8 keep before", cfg_keep, 1);
    mrst_n = 0;
    nbc = 0;
    #1;
    chk("R8 keep dropped", cfg_keep, 0);
    chk("R8 wr_clr", wr_clr, 1);
    cfg_in = 6'h2a;
    repeat (8) ea();
    chk("R1 held rd_clr", rd_clr, 1);
    chk("R1 held oreg_clr", oreg_clr, 1);
    mrst_n = 1;
    repeat (3) eb();
    chk("R6 long reset", short_err, (nbc < 4) ? 1 : 0);
    chk("R5 capture last", cfg_q, 6'h2a);
    chk("R3 resumed keep", cfg_keep, 1);
    prt_n = 1;
    repeat (4) eb();
    chk("R7 final wr_clr", wr_clr, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule